// File: doc/BRIEF.md
# Host Controller Interrupt Status Unit

This block gathers the sixteen event lines of a storage-card host controller's command and data paths into one raw status register. Software clears bits by writing ones to them. The unit also holds an interrupt mask, a global enable bit, and a masked view of the status. It drives one interrupt line and two grouped flags: one for any data-path error and one for any data-path timeout.

Most event bits are sticky. A one-cycle pulse on an event line sets its bit, and the bit stays set until software clears it. The transmit-request and receive-request bits work differently. They follow level inputs from the FIFO threshold logic, so clearing them only takes effect once the level has dropped. When a new event and a clear for the same bit arrive in the same cycle, the event wins. Bit 0 has no event assigned and always reads 0.

Top module: `host_irq_status`

## Requirements
- R1: A one-cycle pulse on a pulse-type event input sets that raw status bit on the next rising edge, and the bit then stays 1 until cleared. The pulse-type bit positions are 1 response error, 2 command done, 3 data transfer over, 6 response CRC, 7 data CRC, 8 response timeout, 9 data read timeout, 10 host timeout, 11 FIFO under/overrun, 12 hardware locked write, 13 start-bit error, 14 auto command done and 15 end-bit error.
- R2: When `clr_we` is 1, each raw bit whose `clr_data` bit is 1 reads 0 after the next edge, unless a new event for that bit arrives in the same cycle. Bits whose `clr_data` bit is 0 keep their value. Writing 16'hFFFF clears every bit that is not being set again in that cycle.
- R3: An event arriving in the same cycle as a clear of its bit wins, so the bit reads 1 after the edge.
- R4: Raw bit 4 (transmit request) is set on every edge where `tx_req_lvl` is 1, and raw bit 5 (receive request) on every edge where `rx_req_lvl` is 1. A clear of either bit only takes effect once its level is 0. `evt_in[4]`, `evt_in[5]` and `evt_in[0]` are ignored, and raw bit 0 always reads 0.
- R5: The mask register resets to 0 and loads `mask_data` on the edge where `mask_we` is 1. `masked_status` always equals `raw_status` AND the mask, with no added delay.
- R6: The global enable resets to 0 and loads `gie_data` on the edge where `gie_we` is 1. `irq` is 1 exactly when the enable is 1 and at least one bit of `masked_status` is 1.
- R7: `data_err` is the OR of raw bits 15, 13, 12, 11 and 7. The mask does not affect it.
- R8: `data_tmo` is the OR of raw bits 10 and 9. The mask does not affect it.
- R9: While `rst_n` is 0 at an edge, the raw status, the mask and the enable all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 16 | Event pulses, one per status bit |
| tx_req_lvl | input | 1 | Transmit FIFO threshold level (bit 4) |
| rx_req_lvl | input | 1 | Receive FIFO threshold level (bit 5) |
| clr_we | input | 1 | Write strobe for clearing status bits |
| clr_data | input | 16 | Clear pattern; a 1 clears that bit |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_data | input | 16 | New mask value |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_data | input | 1 | New global enable value |
| raw_status | output | 16 | Raw latched event status |
| masked_status | output | 16 | Raw status AND mask |
| mask_q | output | 16 | Current mask register |
| gie_q | output | 1 | Current global enable |
| irq | output | 1 | Interrupt request |
| data_err | output | 1 | Any data-error bit set |
| data_tmo | output | 1 | Any data-timeout bit set |

## Verification
Directed sequences check the following:
- A lone pulse, followed by a clear of a different bit, separates set from clear.
- A pulse and a clear of the same bit in one cycle checks that the event wins.
- A clear while a request level is held, then again after the level drops, exposes the level-following behaviour.
- Pulses on the ignored lines 0, 4 and 5 confirm those lines have no effect.
- Setting each summary bit one at a time, each followed by an all-ones clear, checks that every member of each group drives its flag and that no other bit does.

Random traffic follows, mixing sparse pulses, random and all-ones clears, and mask and enable writes. This shows whether masking and the enable gate the interrupt correctly for many different combinations of status and mask.

// File: rtl/host_irq_pkg.sv
// Package: shared bit map and widths of the interrupt status unit.
// Assumes a fixed 16-event map; the group masks below depend on it.
package host_irq_pkg;
    localparam int unsigned EVT_W = 16;

    localparam int unsigned B_TX_REQ = 4;
    localparam int unsigned B_RX_REQ = 5;

    localparam logic [EVT_W-1:0] RSVD_SET  = 16'h0001;
    localparam logic [EVT_W-1:0] LEVEL_SET = 16'h0030;
    localparam logic [EVT_W-1:0] DERR_SET  = 16'hB880; // bits 15,13,12,11,7
    localparam logic [EVT_W-1:0] DTMO_SET  = 16'h0600; // bits 10,9

    typedef enum logic [1:0] {
        SRC_PULSE = 2'd0,
        SRC_LEVEL = 2'd1,
        SRC_NONE  = 2'd2
    } src_kind_e;

    // Kind of source that feeds one status bit.
    function automatic src_kind_e bit_kind(input int unsigned idx);
        if (RSVD_SET[idx])       return SRC_NONE;
        else if (LEVEL_SET[idx]) return SRC_LEVEL;
        else                     return SRC_PULSE;
    endfunction
endpackage

// File: rtl/irq_evt_latch.sv
// Module: sticky raw status register, one flop per bit.
// A set request beats a clear request on the same bit in the same cycle.
// Reserved bits are tied to zero. Assumes set_vec already has the
// level-type bits merged in by the parent.
module irq_evt_latch
    import host_irq_pkg::*;
#(
    parameter int unsigned W = EVT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] raw_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (bit_kind(i) == SRC_NONE) begin : g_rsvd
            // Reserved position: no source, constant zero.
            assign raw_q[i] = 1'b0;
        end else begin : g_live
            logic q;
            // Hold, clear on write-one, set wins over clear.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= (q & ~clr_vec[i]) | set_vec[i];
            end
            assign raw_q[i] = q;
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Module: interrupt mask register and global interrupt enable.
// Both reset to zero and load from their own write strobes.
module irq_mask_reg
    import host_irq_pkg::*;
#(
    parameter int unsigned W = EVT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [W-1:0] mask_data,
    input  logic         gie_we,
    input  logic         gie_data,
    output logic [W-1:0] mask_q,
    output logic         gie_q
);
    // Mask register load.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_data;
    end

    // Global enable load.
    always_ff @(posedge clk) begin
        if (!rst_n)      gie_q <= 1'b0;
        else if (gie_we) gie_q <= gie_data;
    end
endmodule

// File: rtl/irq_group_summary.sv
// Module: combinational summaries of the raw status. It produces the
// masked view, the gated interrupt line, and the data-error and
// data-timeout group flags. Assumes the group sets from the package.
module irq_group_summary
    import host_irq_pkg::*;
#(
    parameter int unsigned W = EVT_W,
    parameter logic [W-1:0] ERR_GRP = DERR_SET,
    parameter logic [W-1:0] TMO_GRP = DTMO_SET
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] mask,
    input  logic         gie,
    output logic [W-1:0] masked,
    output logic         irq,
    output logic         err_any,
    output logic         tmo_any
);
    // Masked view, interrupt and group reductions.
    always_comb begin
        masked  = raw & mask;
        irq     = gie & (|masked);
        err_any = |(raw & ERR_GRP);
        tmo_any = |(raw & TMO_GRP);
    end
endmodule

// File: rtl/host_irq_status.sv
// Top: raw/masked interrupt status unit for a card host controller.
// It merges the pulse events with the FIFO request levels, applies
// write-one-to-clear, and drives the summaries. Assumes the event
// pulses are synchronous to clk.
module host_irq_status
    import host_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] evt_in,
    input  logic        tx_req_lvl,
    input  logic        rx_req_lvl,
    input  logic        clr_we,
    input  logic [15:0] clr_data,
    input  logic        mask_we,
    input  logic [15:0] mask_data,
    input  logic        gie_we,
    input  logic        gie_data,
    output logic [15:0] raw_status,
    output logic [15:0] masked_status,
    output logic [15:0] mask_q,
    output logic        gie_q,
    output logic        irq,
    output logic        data_err,
    output logic        data_tmo
);
    localparam int unsigned W = EVT_W;

    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;

    for (genvar i = 0; i < W; i++) begin : g_src
        if (i == B_TX_REQ) begin : g_tx
            assign set_vec[i] = tx_req_lvl;
        end else if (i == B_RX_REQ) begin : g_rx
            assign set_vec[i] = rx_req_lvl;
        end else if (bit_kind(i) == SRC_PULSE) begin : g_pulse
            assign set_vec[i] = evt_in[i];
        end else begin : g_none
            assign set_vec[i] = 1'b0;
        end
    end

    // Clear request is only live during a clear write.
    always_comb clr_vec = clr_we ? clr_data : '0;

    irq_evt_latch #(.W(W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .raw_q   (raw_status)
    );

    irq_mask_reg #(.W(W)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (mask_we),
        .mask_data (mask_data),
        .gie_we    (gie_we),
        .gie_data  (gie_data),
        .mask_q    (mask_q),
        .gie_q     (gie_q)
    );

    irq_group_summary #(.W(W)) u_sum (
        .raw     (raw_status),
        .mask    (mask_q),
        .gie     (gie_q),
        .masked  (masked_status),
        .irq     (irq),
        .err_any (data_err),
        .tmo_any (data_tmo)
    );
endmodule

// File: rtl/host_irq_status_chk.sv
// Checker: temporal properties of host_irq_status, bound to every instance.
module host_irq_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] evt_in,
    input logic        tx_req_lvl,
    input logic        rx_req_lvl,
    input logic        clr_we,
    input logic [15:0] clr_data,
    input logic [15:0] raw_status,
    input logic [15:0] masked_status,
    input logic [15:0] mask_q,
    input logic        gie_q,
    input logic        irq,
    input logic        data_err,
    input logic        data_tmo
);
    logic [15:0] pulse_in;
    logic [15:0] lvl_in;
    logic [15:0] clr_in;
    always_comb begin
        pulse_in = evt_in & 16'hFFCE;
        lvl_in   = {10'd0, rx_req_lvl, tx_req_lvl, 4'd0};
        clr_in   = clr_we ? clr_data : 16'h0;
    end

    a_r1_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_in != 16'h0) |=> ((raw_status & $past(pulse_in)) == $past(pulse_in)));

    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_status & $past(clr_data & ~pulse_in & ~lvl_in)) == 16'h0));

    a_r3_hold_or_set: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_status != 16'h0) |=> ((raw_status & $past(raw_status & ~clr_in))
                                   == $past(raw_status & ~clr_in)));

    a_r4_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_lvl |=> raw_status[4]);

    a_r4_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req_lvl |=> raw_status[5]);

    a_r4_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        raw_status[0] == 1'b0);

    a_r5_masked_view: assert property (@(posedge clk) disable iff (!rst_n)
        masked_status == (raw_status & mask_q));

    a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (gie_q && (masked_status != 16'h0)));

    a_r7_data_err: assert property (@(posedge clk) disable iff (!rst_n)
        data_err == (raw_status[15] | raw_status[13] | raw_status[12]
                     | raw_status[11] | raw_status[7]));

    a_r8_data_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        data_tmo == (raw_status[10] | raw_status[9]));
endmodule

bind host_irq_status host_irq_status_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_in        (evt_in),
    .tx_req_lvl    (tx_req_lvl),
    .rx_req_lvl    (rx_req_lvl),
    .clr_we        (clr_we),
    .clr_data      (clr_data),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .mask_q        (mask_q),
    .gie_q         (gie_q),
    .irq           (irq),
    .data_err      (data_err),
    .data_tmo      (data_tmo)
);

// File: tb/sim_host_irq_status.sv
// Bench: directed corner cases plus seeded random traffic, compared
// against a bench-side model after every clock edge.
module sim_host_irq_status;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] evt_in;
    logic        tx_req_lvl, rx_req_lvl;
    logic        clr_we;
    logic [15:0] clr_data;
    logic        mask_we;
    logic [15:0] mask_data;
    logic        gie_we, gie_data;
    logic [15:0] raw_status, masked_status, mask_q;
    logic        gie_q, irq, data_err, data_tmo;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] m_raw, m_mask;
    logic        m_gie;

    always #4 clk = ~clk;

    host_irq_status u0 (.*);

    // Expected raw status after one edge, from the requirements.
    function automatic logic [15:0] exp_raw(input logic [15:0] raw,
            input logic [15:0] ev, input logic tx, input logic rx,
            input logic cwe, input logic [15:0] cd);
        logic [15:0] s;
        logic [15:0] c;
        s = ev & 16'hFFCE;
        s[4] = tx;
        s[5] = rx;
        c = cwe ? cd : 16'h0;
        return ((raw & ~c) | s) & 16'hFFFE;
    endfunction

    function automatic logic exp_err(input logic [15:0] r);
        return r[15] | r[13] | r[12] | r[11] | r[7];
    endfunction

    function automatic logic exp_tmo(input logic [15:0] r);
        return r[10] | r[9];
    endfunction

    task automatic cmp(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_in = '0; clr_we = 0; clr_data = '0;
        mask_we = 0; mask_data = '0; gie_we = 0; gie_data = 0;
    endtask

    // Apply the current inputs for one edge, update the model, compare.
    task automatic step(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            m_raw = '0; m_mask = '0; m_gie = 0;
        end else begin
            m_raw = exp_raw(m_raw, evt_in, tx_req_lvl, rx_req_lvl, clr_we, clr_data);
            if (mask_we) m_mask = mask_data;
            if (gie_we)  m_gie  = gie_data;
        end
        #2;
        cmp(tag, "raw_status", raw_status, m_raw);
        cmp(tag, "mask_q", mask_q, m_mask);
        cmp(tag, "masked_status", masked_status, m_raw & m_mask);
        cmp(tag, "irq", {15'd0, irq}, {15'd0, m_gie & (|(m_raw & m_mask))});
        cmp(tag, "data_err", {15'd0, data_err}, {15'd0, exp_err(m_raw)});
        cmp(tag, "data_tmo", {15'd0, data_tmo}, {15'd0, exp_tmo(m_raw)});
        cmp(tag, "gie_q", {15'd0, gie_q}, {15'd0, m_gie});
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_raw = '0; m_mask = '0; m_gie = 0;
        idle_inputs();
        tx_req_lvl = 0; rx_req_lvl = 0;
        rst_n = 0;
        // R9: reset with activity on inputs.
        evt_in = 16'hFFFF; mask_we = 1; mask_data = 16'hFFFF; gie_we = 1; gie_data = 1;
        @(negedge clk);
        step("R9");
        step("R9");
        rst_n = 1;

        // R1: pulse sets bit 3 and it stays.
        evt_in = 16'h0008; step("R1");
        step("R1");
        // R2: clearing bit 3 leaves bit 7 alone.
        evt_in = 16'h0080; step("R2");
        clr_we = 1; clr_data = 16'h0008; step("R2");
        // R3: set and clear of bit 2 together.
        evt_in = 16'h0004; clr_we = 1; clr_data = 16'h0004; step("R3");
        // R2: all-ones clear.
        clr_we = 1; clr_data = 16'hFFFF; step("R2");
        // R4: ignored lines 0, 4, 5.
        evt_in = 16'h0031; step("R4");
        // R4: level-held tx resists clear until dropped.
        tx_req_lvl = 1; step("R4");
        clr_we = 1; clr_data = 16'h0010; step("R4");
        tx_req_lvl = 0; clr_we = 1; clr_data = 16'h0010; step("R4");
        rx_req_lvl = 1; step("R4");
        rx_req_lvl = 0; clr_we = 1; clr_data = 16'hFFFF; step("R4");
        // R7/R8: each bit alone.
        for (int b = 1; b < 16; b++) begin
            if (b == 4 || b == 5) continue;
            evt_in = 16'h1 << b; step("R7");
            clr_we = 1; clr_data = 16'hFFFF; step("R8");
        end
        // R5/R6: mask and enable gating.
        evt_in = 16'h0104; step("R5");
        mask_we = 1; mask_data = 16'h0100; step("R5");
        gie_we = 1; gie_data = 1; step("R6");
        clr_we = 1; clr_data = 16'h0100; step("R6");
        gie_we = 1; gie_data = 0; mask_we = 1; mask_data = 16'hFFFF; step("R6");

        // Random traffic, fixed seed.
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < 3000; k++) begin
            evt_in = 16'h0;
            for (int b = 0; b < 16; b++)
                if ($urandom_range(7) == 0) evt_in[b] = 1'b1;
            if ($urandom_range(9) == 0) tx_req_lvl = ~tx_req_lvl;
            if ($urandom_range(9) == 0) rx_req_lvl = ~rx_req_lvl;
            clr_we = ($urandom_range(3) == 0);
            clr_data = ($urandom_range(4) == 0) ? 16'hFFFF : 16'($urandom);
            mask_we = ($urandom_range(7) == 0);
            mask_data = 16'($urandom);
            gie_we = ($urandom_range(7) == 0);
            gie_data = 1'($urandom);
            step("R3");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule